// File: doc/BRIEF.md
# Sequential GF(2^128) Multiplier for GHASH

This block multiplies a 128-bit data element by a 128-bit hash key in the binary field used by GHASH. The field has the modulus t^128 + t^7 + t^2 + t + 1. The data element arrives in byte-stream form and the result leaves in the same form. Byte 0 of the stream sits in bits [7:0]. The most significant bit of each byte is the lowest-degree coefficient of its group of eight.

A mode input selects how 32-bit words are stored. In big-endian word mode, the four bytes inside every 32-bit word are mirrored on the way in and on the way out. In little-endian word mode they pass through in place. Inside the block the bits of every byte are reversed, so that bit i is the coefficient of t^i.

The key is taken already in that internal order and is not converted. One combinational 64x64 carry-less multiplier is reused for four cycles to build the 256-bit product. A two-step shift-and-XOR fold then reduces it to 128 bits. A final registered stage restores the external byte order.

Top module: `gfm128_seq`

## Requirements
- R1: In little-endian word mode (`be_mode_i`=0), `result_o` equals A·K reduced modulo t^128+t^7+t^2+t+1. Here A is `a_i` with the bits of every byte reversed, and the product is mapped back the same way. Example: GHASH of a single block under a known key gives the standard first-block value.
- R2: In big-endian word mode (`be_mode_i`=1), the bytes inside each 32-bit word of `a_i` are also mirrored before the multiply. The same mirroring is applied to the result. Byte 0 and byte 3 of each word swap, and byte 1 and byte 2 swap.
- R3: `k_i` is used as given, with bit i the coefficient of t^i. With `k_i`=1, `result_o` equals `a_i` in either mode.
- R4: `start_i` is sampled while the block is idle, at clock edge E0. Then `busy_o` is high from E0 up to E6, and `done_o` is high for exactly the one cycle after edge E6.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its original operands, and no second `done_o` follows.
- R6: `result_o` holds its value from the `done_o` cycle until the next accepted start, whatever the inputs do.
- R7: After a synchronous reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R8: A zero value on either operand gives a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiply (sampled when idle) |
| be_mode_i | input | 1 | 1: mirror bytes within each 32-bit word; 0: no mirroring |
| a_i | input | 128 | Data operand, byte-stream form |
| k_i | input | 128 | Key operand, internal bit order |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 128 | Product in the byte-stream form of `a_i` |

## Verification
The bench builds the block with its default parameters: a 128-bit field, 32-bit words and 8-bit bytes. These are the only values for which the reduction taps are defined. With them, both word modes, the standard single-block GHASH value and the identity key can all be reached. A bench-side shift-and-add field multiplier supplies the expected products. The directed part covers the six-cycle latency, a restart attempt in the middle of an operation and result hold under changing inputs.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  // Low-degree taps of the modulus t^128 + t^7 + t^2 + t + 1 (t^0 is implicit)
  localparam int TAP_A = 1;
  localparam int TAP_B = 2;
  localparam int TAP_C = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_RED  = 2'd2,
    ST_OUT  = 2'd3
  } gfm_state_e;
endpackage

// File: rtl/gfm_order_conv.sv
// Maps between byte-stream form and internal polynomial order.
// Bits of every byte are reversed; in word-mirror mode the bytes inside
// each lane are mirrored as well. The mapping is its own inverse.
module gfm_order_conv #(
  parameter int FIELD_W = 128,
  parameter int LANE_W  = 32,
  parameter int BYTE_W  = 8
) (
  input  logic               be_mode,
  input  logic [FIELD_W-1:0] din,
  output logic [FIELD_W-1:0] dout
);
  localparam int NBYTES   = FIELD_W / BYTE_W;
  localparam int LANE_BYT = LANE_W / BYTE_W;

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    localparam int SRC_M = (j / LANE_BYT) * LANE_BYT + (LANE_BYT - 1 - (j % LANE_BYT));
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign dout[j*BYTE_W + b] = be_mode ? din[SRC_M*BYTE_W + (BYTE_W-1-b)]
                                          : din[j*BYTE_W + (BYTE_W-1-b)];
    end
  end
endmodule

// File: rtl/gfm_clmul.sv
// Combinational W x W carry-less multiplier.
module gfm_clmul #(
  parameter int W = 64
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] a_ext;
  assign a_ext = {{W{1'b0}}, op_a};

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      if (op_b[i]) prod = prod ^ (a_ext << i);
    end
  end
endmodule

// File: rtl/gfm_fold.sv
// Two-step reduction of a 4-word product to 2 words.
// Step 1: bits of the upper words that would spill past a word boundary
//         are folded down one word. Step 2: the updated upper words are
//         folded into the lower words with their in-word shifted copies.
module gfm_fold
  import gfm_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [4*HALF_W-1:0] wide,
  output logic [2*HALF_W-1:0] narrow
);
  logic [HALF_W-1:0] lo_w   [2];
  logic [HALF_W-1:0] hi_w   [2];
  logic [HALF_W-1:0] spill  [2];
  logic [HALF_W-1:0] hi_upd [2];
  logic [HALF_W-1:0] lo_upd [2];

  for (genvar i = 0; i < 2; i++) begin : g_word
    assign lo_w[i]  = wide[i*HALF_W +: HALF_W];
    assign hi_w[i]  = wide[(2+i)*HALF_W +: HALF_W];
    assign spill[i] = (hi_w[i] >> (HALF_W - TAP_A))
                    ^ (hi_w[i] >> (HALF_W - TAP_B))
                    ^ (hi_w[i] >> (HALF_W - TAP_C));
  end

  // Spill of the top word lands in the lower high word; spill of the
  // lower high word lands in the upper low word.
  assign hi_upd[0] = hi_w[0] ^ spill[1];
  assign hi_upd[1] = hi_w[1];
  assign lo_upd[0] = lo_w[0];
  assign lo_upd[1] = lo_w[1] ^ spill[0];

  for (genvar i = 0; i < 2; i++) begin : g_out
    assign narrow[i*HALF_W +: HALF_W] = lo_upd[i] ^ hi_upd[i]
                                      ^ (hi_upd[i] << TAP_A)
                                      ^ (hi_upd[i] << TAP_B)
                                      ^ (hi_upd[i] << TAP_C);
  end
endmodule

// File: rtl/gfm128_seq.sv
module gfm128_seq
  import gfm_pkg::*;
#(
  parameter int FIELD_W = 128,
  parameter int LANE_W  = 32,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               be_mode_i,
  input  logic [FIELD_W-1:0] a_i,
  input  logic [FIELD_W-1:0] k_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FIELD_W-1:0] result_o
);
  localparam int HALF_W = FIELD_W / 2;
  localparam int WIDE_W = 2 * FIELD_W;

  gfm_state_e          state_q;
  logic [1:0]          step_q;
  logic [FIELD_W-1:0]  u_q, v_q, red_q, res_q;
  logic                be_q, busy_q, done_q;
  logic [WIDE_W-1:0]   acc_q;

  logic [FIELD_W-1:0]  a_int, red_ext, fold_out;
  logic [HALF_W-1:0]   pa, pb;
  logic [FIELD_W-1:0]  pp;
  logic [WIDE_W-1:0]   pp_pos;

  gfm_order_conv #(.FIELD_W(FIELD_W), .LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_conv_in (
    .be_mode(be_mode_i), .din(a_i), .dout(a_int)
  );

  gfm_order_conv #(.FIELD_W(FIELD_W), .LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_conv_out (
    .be_mode(be_q), .din(red_q), .dout(red_ext)
  );

  // Operand selection per step: 0: u0*v0, 1: u0*v1, 2: u1*v0, 3: u1*v1
  always_comb begin
    pa = step_q[1] ? u_q[FIELD_W-1:HALF_W] : u_q[HALF_W-1:0];
    pb = step_q[0] ? v_q[FIELD_W-1:HALF_W] : v_q[HALF_W-1:0];
  end

  gfm_clmul #(.W(HALF_W)) u_clmul (
    .op_a(pa), .op_b(pb), .prod(pp)
  );

  always_comb begin
    case (step_q)
      2'd0:    pp_pos = {{FIELD_W{1'b0}}, pp};
      2'd3:    pp_pos = {pp, {FIELD_W{1'b0}}};
      default: pp_pos = {{HALF_W{1'b0}}, pp, {HALF_W{1'b0}}};
    endcase
  end

  gfm_fold #(.HALF_W(HALF_W)) u_fold (
    .wide(acc_q), .narrow(fold_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      u_q     <= '0;
      v_q     <= '0;
      be_q    <= 1'b0;
      acc_q   <= '0;
      red_q   <= '0;
      res_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            u_q     <= a_int;
            v_q     <= k_i;
            be_q    <= be_mode_i;
            acc_q   <= '0;
            step_q  <= '0;
            busy_q  <= 1'b1;
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          acc_q  <= acc_q ^ pp_pos;
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) state_q <= ST_RED;
        end
        ST_RED: begin
          red_q   <= fold_out;
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          res_q   <= red_ext;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/gfm128_seq_chk.sv
module gfm128_seq_chk #(
  parameter int FIELD_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [FIELD_W-1:0] result_o
);
  logic [2:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                         since_q <= '0;
    else if (start_i && !busy_o)     since_q <= 3'd1;
    else if (since_q == 3'd6)        since_q <= '0;
    else if (since_q != '0)          since_q <= since_q + 3'd1;
  end

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && result_o == '0));

  // R4
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    since_q == 3'd6 |=> done_o);

  // R4
  done_only_on_time_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(since_q) == 3'd6 && !busy_o));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && since_q != 3'd6) |=> busy_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o) |-> $stable(result_o));
endmodule

bind gfm128_seq gfm128_seq_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/gfm128_seq_test.sv
module gfm128_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          be_mode_i = 1'b0;
  logic [FW-1:0] a_i = '0;
  logic [FW-1:0] k_i = '0;
  logic          busy_o, done_o;
  logic [FW-1:0] result_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfm128_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .be_mode_i(be_mode_i),
    .a_i(a_i), .k_i(k_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // ---- reference model ----
  function automatic logic [FW-1:0] bit_rev_bytes(input logic [FW-1:0] x);
    logic [FW-1:0] y;
    for (int j = 0; j < FW/8; j++)
      for (int b = 0; b < 8; b++) y[j*8+b] = x[j*8+7-b];
    return y;
  endfunction

  function automatic logic [FW-1:0] mirror_words(input logic [FW-1:0] x);
    logic [FW-1:0] y;
    for (int w = 0; w < FW/32; w++)
      for (int j = 0; j < 4; j++) y[w*32 + j*8 +: 8] = x[w*32 + (3-j)*8 +: 8];
    return y;
  endfunction

  function automatic logic [FW-1:0] field_mul(input logic [FW-1:0] x, input logic [FW-1:0] y);
    logic [FW-1:0] z = '0;
    logic [FW-1:0] s = x;
    for (int i = 0; i < FW; i++) begin
      if (y[i]) z ^= s;
      s = s[FW-1] ? ((s << 1) ^ 128'h87) : (s << 1);
    end
    return z;
  endfunction

  function automatic logic [FW-1:0] model(input logic be, input logic [FW-1:0] a, input logic [FW-1:0] k);
    logic [FW-1:0] ai = bit_rev_bytes(be ? mirror_words(a) : a);
    logic [FW-1:0] r  = field_mul(ai, k);
    return be ? mirror_words(bit_rev_bytes(r)) : bit_rev_bytes(r);
  endfunction

  task automatic check(input string req, input logic [FW-1:0] got, input logic [FW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive one operation; returns result and number of edges from E0 to done.
  task automatic run_op(input logic be, input logic [FW-1:0] a, input logic [FW-1:0] k,
                        output logic [FW-1:0] res, output int lat);
    @(negedge clk);
    be_mode_i = be; a_i = a; k_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = result_o;
  endtask

  // ---- vector table: {mode, A, K} ----
  localparam int NV = 6;
  localparam logic [256:0] VEC [NV] = '{
    {1'b0, 128'h0123456789abcdeffedcba9876543210, 128'h00000000000000000000000000000002},
    {1'b0, 128'hffffffffffffffffffffffffffffffff, 128'hffffffffffffffffffffffffffffffff},
    {1'b1, 128'hdeadbeef00112233445566778899aabb, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0},
    {1'b1, 128'h80000000000000000000000000000001, 128'h80000000000000000000000000000000},
    {1'b0, 128'h13579bdf2468ace0fdb97531eca86420, 128'h5a5a5a5aa5a5a5a5c3c3c3c33c3c3c3c},
    {1'b1, 128'h00000000000000000000000000000080, 128'h40000000000000000000000000000001}
  };

  logic watchdog_hit = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    watchdog_hit = 1'b1;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [FW-1:0] res, first, held;
    int lat;

    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 busy", {127'b0, busy_o}, '0);
    check("R7 done", {127'b0, done_o}, '0);
    check("R7 result", result_o, '0);
    rst = 1'b0;

    // R1 R2 table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][256], VEC[i][255:128], VEC[i][127:0], res, lat);
      check(VEC[i][256] ? "R2 table" : "R1 table", res,
            model(VEC[i][256], VEC[i][255:128], VEC[i][127:0]));
    end

    // R1: known GHASH first-block value (LE mode, byte 0 in bits [7:0])
    run_op(1'b0, 128'h78feb271b9c228f392a3b660ceda8803,
           bit_rev_bytes(128'h2e2b34ca59fa4c883b2c8aefd44be966), res, lat);
    check("R1 known", res, 128'hb7de5353_68b0852c_88627091_46c72e5e);
    // R4: latency
    check("R4 latency", FW'(lat), FW'(6));

    // R3: identity key, both modes
    run_op(1'b0, 128'hcafef00d_12345678_9abcdef0_0badc0de, 128'h1, res, lat);
    check("R3 le", res, 128'hcafef00d_12345678_9abcdef0_0badc0de);
    run_op(1'b1, 128'hcafef00d_12345678_9abcdef0_0badc0de, 128'h1, res, lat);
    check("R3 be", res, 128'hcafef00d_12345678_9abcdef0_0badc0de);

    // R2: mirroring visible: single byte 0x80 in byte 0 is t^24 in BE mode
    run_op(1'b1, 128'h80, 128'h1_0000_0000, res, lat);
    check("R2 lane", res, model(1'b1, 128'h80, 128'h1_0000_0000));

    // R8: zero operands
    run_op(1'b0, '0, 128'h1234, res, lat);
    check("R8 a zero", res, '0);
    run_op(1'b1, 128'hffff0000ffff0000, '0, res, lat);
    check("R8 k zero", res, '0);

    // R5: start while busy is ignored
    @(negedge clk);
    be_mode_i = 1'b0; a_i = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    k_i = 128'habcdef; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    a_i = 128'h9999; k_i = 128'h7; start_i = 1'b1;   // mid-operation restart
    @(negedge clk);
    start_i = 1'b0;
    lat = 2;
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
    first = result_o;
    check("R5 result", first, model(1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'habcdef));
    check("R5 latency", FW'(lat), FW'(6));
    begin
      int extra_done = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (done_o) extra_done++;
      end
      check("R5 no second done", FW'(extra_done), '0);
    end

    // R6: result holds while inputs change and no start is given
    held = result_o;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      a_i = {4{32'(c * 7919)}}; k_i = ~a_i; be_mode_i = c[0];
    end
    check("R6 hold", result_o, held);
    check("R6 busy idle", {127'b0, busy_o}, '0);

    if (!watchdog_hit) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule